// File: doc/BRIEF.md
# Dual-Slave Three/Four-Wire SPI Register Master

This block lets on-chip logic read and write the configuration registers of two external slaves: a data converter and a clock generator. Both slaves share one serial clock and one bidirectional data line, and each slave has its own active-low enable. A host presents one request at a time. The request holds a device select, a read/write flag, a register address and a write byte. The master turns the request into a fixed-length serial frame and runs it on the pins. When it finishes, it returns a one-cycle completion pulse together with the byte it captured.

The master has no tristate pad of its own. It provides an output value, an output enable and a separate direction signal for an external bidirectional buffer. During the data part of a read, the master releases the line and lowers the direction signal. A run-time mode input selects where the returned bits are sampled. In three-wire mode they come from the shared line. In four-wire mode they come from a separate slave-output pin. The serial clock rate comes from a programmable half-period count of system clocks.

Top module: `cfg_spi_master`

## Requirements
- R1: During a frame, only the enable of the selected device goes low: `cs_cnv_n_o` when `req_dev_i`=0, `cs_clk_n_o` when `req_dev_i`=1. The other enable stays high for the whole frame.
- R2: A frame is 23 bits, sent MSB first. The first bit is the access flag (1 = read, 0 = write). A 14-bit address field follows, then an 8-bit data field. For writes the data field carries `req_wdata_i`. The address is sent on reads as well as on writes.
- R3: For the converter (device 0), the address field is `req_addr_i[13:0]`. For the clock generator (device 1), the field is one zero bit followed by `req_addr_i[12:0]`. Address bits above the selected device's width have no effect on the frame.
- R4: Each bit takes one serial clock period. The period has a low half followed by a high half, and each half lasts `half_div_i` system clocks (0 counts as 1). The data line changes only at the start of a low half and holds steady through the high half. The half count is captured when the request is accepted.
- R5: When idle, `sclk_o` is low, both enables are high, `dir_o` and `sdio_oe_o` are high, and `sdio_o` is 0.
- R6: In a read, `sdio_oe_o` and `dir_o` are low during exactly the 8 data-bit periods. They are high at every other time, including the whole of a write.
- R7: A read samples one returned bit at each of the 8 rising serial clock edges of the data field, MSB first. When `four_wire_i`=0 the bits come from `sdio_i`; when it is 1 they come from `miso_i`. The mode is captured when the request is accepted.
- R8: After the final falling clock edge, the enable stays low for one more half period and then rises. Two more idle half periods follow. After that, `done_o` pulses for one cycle with `rdata_o`, which is the read byte, or 0 after a write. The whole frame lasts 49 half periods from acceptance.
- R9: `req_ready_o` is high only while idle. A request is accepted on a clock edge where both `req_valid_i` and `req_ready_o` are high. A request presented while busy is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid_i | input | 1 | request present |
| req_ready_o | output | 1 | master idle, request can be taken |
| req_dev_i | input | 1 | 0 = converter, 1 = clock generator |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | 16 | register address |
| req_wdata_i | input | 8 | write byte |
| four_wire_i | input | 1 | 1 = sample read data from `miso_i` |
| half_div_i | input | 8 | system clocks per serial clock half period |
| done_o | output | 1 | one-cycle completion pulse |
| rdata_o | output | 8 | captured byte, valid with `done_o` |
| sclk_o | output | 1 | serial clock |
| cs_cnv_n_o | output | 1 | converter enable, active low |
| cs_clk_n_o | output | 1 | clock generator enable, active low |
| sdio_o | output | 1 | value driven onto the shared data line |
| sdio_oe_o | output | 1 | master drives the shared line |
| sdio_i | input | 1 | shared data line as seen at the pad |
| miso_i | input | 1 | separate slave output for four-wire reads |
| dir_o | output | 1 | external buffer direction, 1 = toward slaves |

## Verification
The embedded properties are checked on every cycle. They cover the following: at most one enable is low; the line is released only inside the data field of a read; the clock toggles only on a divider tick; the data line is steady while the clock is high; the idle pin levels are correct; and the completion flag is a single-cycle pulse. Other behaviour depends on an actual slave and on exact cycle positions, and only the bench scenarios can show it. This includes the bit contents of each frame, the zero padding bit, the position of the enable release and of the completion pulse for several divider values, and whether a read returns the written byte over the shared line or over the separate pin. It also includes the rule that a request made while busy starts nothing.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_TAIL  = 2'd2,
        PH_GAP   = 2'd3
    } phase_e;

    localparam int unsigned NUM_DEV = 2;

endpackage

// File: rtl/cfg_spi_tick.sv
module cfg_spi_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_st_t;

    tick_st_t cur_q, nxt_d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        nxt_d  = cur_q;
        lim    = (half_i == '0) ? '0 : half_i - 1'b1;
        tick_o = run_i && (cur_q.cnt == lim);
        if (!run_i || tick_o) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame #(
    parameter int HOST_AW = 16,
    parameter int DATA_W  = 8,
    parameter int AW_CNV  = 14,
    parameter int AW_CLK  = 13,
    localparam int AW_MAX  = (AW_CNV > AW_CLK) ? AW_CNV : AW_CLK,
    localparam int FRAME_W = 1 + AW_MAX + DATA_W
) (
    input  logic               dev_i,
    input  logic               rd_i,
    input  logic [HOST_AW-1:0] addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [FRAME_W-1:0] frame_o
);

    logic [AW_MAX-1:0] afield;

    // address field: each bit either passes, is masked by device, or is pad
    for (genvar g = 0; g < AW_MAX; g++) begin : g_abit
        if (g < AW_CNV && g < AW_CLK) begin : g_both
            assign afield[g] = addr_i[g];
        end else if (g < AW_CNV) begin : g_cnv_only
            assign afield[g] = ~dev_i & addr_i[g];
        end else if (g < AW_CLK) begin : g_clk_only
            assign afield[g] = dev_i & addr_i[g];
        end else begin : g_pad
            assign afield[g] = 1'b0;
        end
    end

    if (HOST_AW > AW_MAX) begin : g_hi
        logic unused_hi_addr;
        assign unused_hi_addr = ^addr_i[HOST_AW-1:AW_MAX];
    end

    assign frame_o = {rd_i, afield, (rd_i ? {DATA_W{1'b0}} : wdata_i)};

endmodule

// File: rtl/cfg_spi_engine.sv
module cfg_spi_engine
    import cfg_spi_pkg::*;
#(
    parameter int FRAME_W = 23,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               dev_i,
    input  logic               rd_i,
    input  logic               four_wire_i,
    input  logic               sdio_i,
    input  logic               miso_i,
    output logic               busy_o,
    output logic               sclk_o,
    output logic [NUM_DEV-1:0] cs_n_o,
    output logic               sdio_o,
    output logic               oe_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int IDX_W = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_W);

    typedef struct packed {
        phase_e             st;
        logic [FRAME_W-1:0] shreg;
        logic [IDX_W-1:0]   bidx;
        logic [DATA_W-1:0]  rx;
        logic               rd;
        logic               four;
        logic               sclk;
        logic               oe;
        logic               gap;
        logic               done;
        logic [NUM_DEV-1:0] cs_n;
    } eng_st_t;

    eng_st_t cur_q, nxt_d;
    logic    rx_bit;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        rx_bit     = cur_q.four ? miso_i : sdio_i;
        unique case (cur_q.st)
            PH_IDLE: begin
                if (start_i) begin
                    nxt_d.st    = PH_SHIFT;
                    nxt_d.shreg = frame_i;
                    nxt_d.rd    = rd_i;
                    nxt_d.four  = four_wire_i;
                    nxt_d.rx    = '0;
                    nxt_d.bidx  = LAST_IDX;
                    nxt_d.sclk  = 1'b0;
                    nxt_d.oe    = 1'b1;
                    nxt_d.gap   = 1'b0;
                    nxt_d.cs_n  = '1;
                    nxt_d.cs_n[dev_i] = 1'b0;
                end
            end
            PH_SHIFT: begin
                if (tick_i) begin
                    if (!cur_q.sclk) begin
                        nxt_d.sclk = 1'b1;
                        if (cur_q.rd && (cur_q.bidx < DATA_IDX)) begin
                            nxt_d.rx = {cur_q.rx[DATA_W-2:0], rx_bit};
                        end
                    end else begin
                        nxt_d.sclk  = 1'b0;
                        nxt_d.shreg = cur_q.shreg << 1;
                        if (cur_q.bidx == '0) begin
                            nxt_d.st = PH_TAIL;
                            nxt_d.oe = 1'b1;
                        end else begin
                            nxt_d.bidx = cur_q.bidx - 1'b1;
                            nxt_d.oe   = !(cur_q.rd && ((cur_q.bidx - 1'b1) < DATA_IDX));
                        end
                    end
                end
            end
            PH_TAIL: begin
                if (tick_i) begin
                    nxt_d.st   = PH_GAP;
                    nxt_d.cs_n = '1;
                    nxt_d.gap  = 1'b0;
                end
            end
            PH_GAP: begin
                if (tick_i) begin
                    if (!cur_q.gap) begin
                        nxt_d.gap = 1'b1;
                    end else begin
                        nxt_d.st   = PH_IDLE;
                        nxt_d.done = 1'b1;
                    end
                end
            end
            default: nxt_d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.st   <= PH_IDLE;
            cur_q.oe   <= 1'b1;
            cur_q.cs_n <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o  = (cur_q.st != PH_IDLE);
    assign sclk_o  = cur_q.sclk;
    assign cs_n_o  = cur_q.cs_n;
    assign oe_o    = cur_q.oe;
    assign sdio_o  = cur_q.oe & cur_q.shreg[FRAME_W-1];
    assign done_o  = cur_q.done;
    assign rdata_o = cur_q.rx;

    // R1: never two enables low together
    a_r1_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cur_q.cs_n) <= 1)
        else $error("a_r1_single_enable");

    // R6: line released only inside the data field of a read
    a_r6_release_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.oe |-> (cur_q.rd && cur_q.st == PH_SHIFT && cur_q.bidx < DATA_IDX))
        else $error("a_r6_release_in_read");

    // R4: serial clock moves only on a divider tick
    a_r4_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st != PH_IDLE && !tick_i) |=> $stable(cur_q.sclk))
        else $error("a_r4_edge_on_tick");

    // R4: data held through the high half
    a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.sclk && !tick_i) |=> $stable(sdio_o))
        else $error("a_r4_hold_high");

    // R5: idle pin levels
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PH_IDLE) |-> (cur_q.cs_n == '1 && !cur_q.sclk && cur_q.oe))
        else $error("a_r5_idle_quiet");

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.done |=> !cur_q.done)
        else $error("a_r8_done_pulse");

endmodule

// File: rtl/cfg_spi_master.sv
module cfg_spi_master
    import cfg_spi_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int HOST_AW = 16,
    parameter int DATA_W  = 8,
    parameter int AW_CNV  = 14,
    parameter int AW_CLK  = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic               req_dev_i,
    input  logic               req_rd_i,
    input  logic [HOST_AW-1:0] req_addr_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    input  logic               four_wire_i,
    input  logic [DIV_W-1:0]   half_div_i,
    output logic               done_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               sclk_o,
    output logic               cs_cnv_n_o,
    output logic               cs_clk_n_o,
    output logic               sdio_o,
    output logic               sdio_oe_o,
    input  logic               sdio_i,
    input  logic               miso_i,
    output logic               dir_o
);

    localparam int AW_MAX  = (AW_CNV > AW_CLK) ? AW_CNV : AW_CLK;
    localparam int FRAME_W = 1 + AW_MAX + DATA_W;

    typedef struct packed {
        logic [DIV_W-1:0] half;
    } top_st_t;

    top_st_t cur_q, nxt_d;
    logic               busy;
    logic               start;
    logic               tick;
    logic               oe;
    logic [NUM_DEV-1:0] cs_n;
    logic [FRAME_W-1:0] frame;

    assign start       = req_valid_i && !busy;
    assign req_ready_o = !busy;

    always_comb begin
        nxt_d = cur_q;
        if (start) begin
            nxt_d.half = half_div_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    cfg_spi_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .half_i (cur_q.half),
        .tick_o (tick)
    );

    cfg_spi_frame #(
        .HOST_AW (HOST_AW),
        .DATA_W  (DATA_W),
        .AW_CNV  (AW_CNV),
        .AW_CLK  (AW_CLK)
    ) u_frame (
        .dev_i   (req_dev_i),
        .rd_i    (req_rd_i),
        .addr_i  (req_addr_i),
        .wdata_i (req_wdata_i),
        .frame_o (frame)
    );

    cfg_spi_engine #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .start_i     (start),
        .frame_i     (frame),
        .dev_i       (req_dev_i),
        .rd_i        (req_rd_i),
        .four_wire_i (four_wire_i),
        .sdio_i      (sdio_i),
        .miso_i      (miso_i),
        .busy_o      (busy),
        .sclk_o      (sclk_o),
        .cs_n_o      (cs_n),
        .sdio_o      (sdio_o),
        .oe_o        (oe),
        .done_o      (done_o),
        .rdata_o     (rdata_o)
    );

    assign cs_cnv_n_o = cs_n[0];
    assign cs_clk_n_o = cs_n[1];
    assign sdio_oe_o  = oe;
    assign dir_o      = oe;

    // R9: no request can be taken while a slave is enabled
    a_r9_ready_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_cnv_n_o || !cs_clk_n_o) |-> !req_ready_o)
        else $error("a_r9_ready_low_in_frame");

endmodule

// File: tb/tb_cfg_spi_master.sv
module tb_cfg_spi_master;

    localparam int NBITS = 23;
    localparam int NHALF = 2 * NBITS + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_dev = 1'b0;
    logic        req_rd = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        four_wire = 1'b0;
    logic [7:0]  half_div = 8'd2;
    logic        done;
    logic [7:0]  rdata;
    logic        sclk_o, cs_cnv_n, cs_clk_n, sdio_o, sdio_oe, sdio_i, miso_i, dir_o;

    int n_chk = 0;
    int n_bad = 0;
    int pad_err = 0;
    int contention = 0;
    bit finished = 1'b0;

    // slave model state
    int         s_cnt = 0;
    logic [14:0] s_hdr = '0;
    logic [7:0] s_dat = '0;
    logic       s_dev = 1'b0;
    logic [7:0] s_byte;
    logic [7:0] s_cfg;
    logic       s_sdio_en = 1'b0, s_sdio_v = 1'b0;
    logic       s_miso_en = 1'b0, s_miso_v = 1'b0;
    logic [7:0] mem_c [int];
    logic [7:0] mem_k [int];

    always #10 clk = ~clk;

    assign sdio_i = sdio_oe ? sdio_o : (s_sdio_en ? s_sdio_v : 1'b1);
    assign miso_i = s_miso_en ? s_miso_v : 1'b1;

    cfg_spi_master dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_dev_i   (req_dev),
        .req_rd_i    (req_rd),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .four_wire_i (four_wire),
        .half_div_i  (half_div),
        .done_o      (done),
        .rdata_o     (rdata),
        .sclk_o      (sclk_o),
        .cs_cnv_n_o  (cs_cnv_n),
        .cs_clk_n_o  (cs_clk_n),
        .sdio_o      (sdio_o),
        .sdio_oe_o   (sdio_oe),
        .sdio_i      (sdio_i),
        .miso_i      (miso_i),
        .dir_o       (dir_o)
    );

    function automatic logic [7:0] srd(input logic d, input int a);
        if (d) return mem_k.exists(a) ? mem_k[a] : 8'h00;
        return mem_c.exists(a) ? mem_c[a] : 8'h00;
    endfunction

    // slave: capture on rising serial clock
    always @(posedge sclk_o) begin
        if (!cs_cnv_n || !cs_clk_n) begin
            s_dev = !cs_clk_n;
            if (s_cnt < 15) s_hdr = {s_hdr[13:0], sdio_i};
            else if (!s_hdr[14]) s_dat = {s_dat[6:0], sdio_i};
            s_cnt++;
            if (s_cnt == 15 && s_dev && s_hdr[13]) pad_err++;
            if (s_cnt == 23 && !s_hdr[14]) begin
                if (s_dev) mem_k[int'(s_hdr[12:0])] = s_dat;
                else       mem_c[int'(s_hdr[13:0])] = s_dat;
            end
        end
    end

    // slave: present read bits after falling serial clock
    always @(negedge sclk_o) begin
        if ((!cs_cnv_n || !cs_clk_n) && s_hdr[14] && s_cnt >= 15 && s_cnt < 23) begin
            s_byte = srd(s_dev, s_dev ? int'(s_hdr[12:0]) : int'(s_hdr[13:0]));
            s_cfg  = srd(s_dev, 2);
            if (s_cfg[7]) begin
                s_miso_en = 1'b1; s_miso_v = s_byte[7 - (s_cnt - 15)];
            end else begin
                s_sdio_en = 1'b1; s_sdio_v = s_byte[7 - (s_cnt - 15)];
            end
        end else begin
            s_sdio_en = 1'b0; s_miso_en = 1'b0;
        end
    end

    always @(posedge cs_cnv_n or posedge cs_clk_n) begin
        s_cnt = 0; s_sdio_en = 1'b0; s_miso_en = 1'b0;
    end

    always @(negedge clk) if (sdio_oe && s_sdio_en) contention++;

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic logic [22:0] mk_frame(input logic d, input logic rd,
                                             input logic [15:0] a, input logic [7:0] w);
        logic [22:0] f = '0;
        f[22] = rd;
        if (d) f[20:8] = a[12:0];
        else   f[21:8] = a[13:0];
        if (!rd) f[7:0] = w;
        return f;
    endfunction

    // one transaction with a cycle-by-cycle reference of every pin
    task automatic txn(input logic d, input logic rd, input logic [15:0] a,
                       input logic [7:0] w, input logic fw, input logic [7:0] hd,
                       input logic [7:0] exp_rd, input bit poke, input string tag);
        int he = (hd == 0) ? 1 : int'(hd);
        logic [22:0] f = mk_frame(d, rd, a, w);
        int cs_bad = 0, sck_bad = 0, oe_bad = 0, sd_bad = 0, hs_bad = 0;
        logic [7:0] got_rd = 8'hxx;
        @(negedge clk);
        req_dev = d; req_rd = rd; req_addr = a; req_wdata = w;
        four_wire = fw; half_div = hd; req_valid = 1'b1;
        for (int k = 0; k <= NHALF * he; k++) begin
            int h = k / he;
            logic e_cc, e_ck, e_sck, e_oe, e_sd, e_dn;
            bit sd_chk;
            @(negedge clk);
            e_sck = 1'b0; e_oe = 1'b1; e_sd = 1'b0; sd_chk = 1'b1;
            e_dn = (h == NHALF);
            e_cc = 1'b1; e_ck = 1'b1;
            if (h <= 2 * NBITS) begin
                if (d) e_ck = 1'b0; else e_cc = 1'b0;
            end
            if (h < 2 * NBITS) begin
                int b = h / 2;
                e_sck = (h % 2) == 1;
                e_oe  = !(rd && b >= 15);
                if (e_oe) e_sd = f[22 - b]; else sd_chk = 1'b0;
            end
            if (cs_cnv_n !== e_cc || cs_clk_n !== e_ck) cs_bad++;
            if (sclk_o !== e_sck) sck_bad++;
            if (sdio_oe !== e_oe || dir_o !== e_oe) oe_bad++;
            if (sd_chk && sdio_o !== e_sd) sd_bad++;
            if (done !== e_dn || req_ready !== e_dn) hs_bad++;
            if (done === 1'b1) got_rd = rdata;
            if (k == 0) req_valid = 1'b0;
            if (poke && k == 5) begin
                req_valid = 1'b1; req_dev = ~d; req_rd = 1'b0; half_div = 8'd1;
            end
            if (poke && k == 9) req_valid = 1'b0;
        end
        chk("R1", {tag, " enable timing mismatches"}, cs_bad, 0);
        chk("R4", {tag, " sclk mismatches"}, sck_bad, 0);
        chk("R6", {tag, " oe/dir mismatches"}, oe_bad, 0);
        chk("R2", {tag, " frame bit mismatches"}, sd_bad, 0);
        chk("R8", {tag, " done/ready mismatches"}, hs_bad, 0);
        chk("R7", {tag, " returned byte"}, int'(got_rd), int'(exp_rd));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset / idle state
        chk("R5", "cs_cnv_n after reset", int'(cs_cnv_n), 1);
        chk("R5", "cs_clk_n after reset", int'(cs_clk_n), 1);
        chk("R5", "sclk after reset", int'(sclk_o), 0);
        chk("R5", "dir/oe after reset", int'({dir_o, sdio_oe}), 3);
        chk("R5", "sdio_o after reset", int'(sdio_o), 0);
        chk("R9", "ready after reset", int'({req_ready, done}), 2);

        // R3: upper address bits set, must not reach the frame
        txn(1'b0, 1'b0, 16'hEA5C, 8'hA5, 1'b0, 8'd2, 8'h00, 1'b0, "wr cnv");
        // R3: clock generator pad bit zero although addr[13]=1
        txn(1'b1, 1'b0, 16'hF123, 8'h3C, 1'b0, 8'd3, 8'h00, 1'b0, "wr clk");
        // R7 three-wire readback
        txn(1'b0, 1'b1, 16'h2A5C, 8'hFF, 1'b0, 8'd2, 8'hA5, 1'b0, "rd cnv 3w");
        txn(1'b1, 1'b1, 16'h1123, 8'h00, 1'b0, 8'd1, 8'h3C, 1'b0, "rd clk 3w");
        // R3: bit 14 ignored for the converter
        txn(1'b0, 1'b1, 16'h6A5C, 8'h00, 1'b0, 8'd2, 8'hA5, 1'b0, "rd cnv hi");
        // R4: half count 0 acts as 1; enable four-wire in converter slave
        txn(1'b0, 1'b0, 16'h0002, 8'h80, 1'b0, 8'd0, 8'h00, 1'b0, "wr cnv cfg");
        // R7 four-wire readback from miso
        txn(1'b0, 1'b1, 16'h2A5C, 8'h00, 1'b1, 8'd2, 8'hA5, 1'b0, "rd cnv 4w");
        // R9: request while busy is ignored
        txn(1'b1, 1'b0, 16'h0002, 8'h80, 1'b0, 8'd2, 8'h00, 1'b1, "wr clk cfg busy-poke");
        txn(1'b1, 1'b1, 16'h1123, 8'h00, 1'b1, 8'd4, 8'h3C, 1'b0, "rd clk 4w");
        txn(1'b0, 1'b0, 16'h0000, 8'h5A, 1'b1, 8'd2, 8'h00, 1'b0, "wr cnv 0");
        txn(1'b0, 1'b1, 16'h0000, 8'h00, 1'b1, 8'd3, 8'h5A, 1'b0, "rd cnv 0");
        txn(1'b1, 1'b1, 16'h0002, 8'h00, 1'b1, 8'd2, 8'h80, 1'b0, "rd clk cfg");

        // R9: after the poked frame, no extra frame started
        repeat (5) @(negedge clk);
        chk("R9", "enables idle after all frames", int'({cs_cnv_n, cs_clk_n}), 3);
        chk("R3", "pad bit errors seen by slave", pad_err, 0);
        chk("R6", "line contention cycles", contention, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule